// File: doc/BRIEF.md
# Configurable Lookup-Table Logic Cell

This block is one programmable logic cell of the kind that is repeated across an FPGA fabric. It has two 4-input lookup tables, F and G. A third 3-input lookup table, H, can merge their results with a direct cell input. A single cell can therefore produce any function of five inputs and some wider functions, such as parity over nine inputs.

Two combinational outputs show table results directly. Two registered outputs come from flip-flops that have a clock enable. The data source of each flip-flop is chosen by the configuration, and each flip-flop has a configured synchronous set/clear value.

All truth tables and steering selects sit in one 50-bit configuration register. That register is filled serially, most significant bit first, while `cfg_en` is high. After loading, `cfg_en` returns low and the cell runs as programmed.

Top module: `lut_cell`

## Requirements
- R1: `x_out` with the X view set to F gives bit `f_in` (0..15) of the 16-bit F table. `y_out` with the Y view set to G gives bit `g_in` of the G table.
- R2: H returns bit `{hb, ha, h_dir}` (0..7, with `h_dir` as the least significant bit) of the 8-bit H table. `ha` is the F result when its select bit is 0 and `h_alt_a` when it is 1. `hb` is the G result when its select bit is 0 and `h_alt_b` when it is 1.
- R3: `x_out` shows F when its view bit is 0 and H when it is 1. `y_out` shows G when its view bit is 0 and H when it is 1.
- R4: Each rising `clk` edge with `cfg_en` high shifts `cfg_bit` into the 50-bit configuration register. After 50 shifts the bits land, first bit to last, as follows:
  - F table, bit 15 down to 0.
  - G table, bit 15 down to 0.
  - H table, bit 7 down to 0.
  - The `ha` select and the `hb` select.
  - The X view bit and the Y view bit.
  - The XQ source (2 bits) and the XQ init bit.
  - The YQ source (2 bits) and the YQ init bit.
  With `cfg_en` low, the register holds its contents whatever `cfg_bit` does.
- R5: A flip-flop source code of 00 selects F, 01 selects G, 10 selects H and 11 selects the direct input (`x_din` for XQ, `y_din` for YQ).
- R6: With `cfg_en` and `ff_sr` low, a flip-flop loads its selected source on a rising edge when its clock enable is high. It holds its value when the enable is low.
- R7: `rst_n` low at a rising edge clears the whole configuration register and both flip-flops to 0.
- R8: While `cfg_en` is high, each rising edge loads both flip-flops with the init bit that the configuration register holds before that edge, regardless of the clock enables.
- R9: With `ff_sr` high, a rising edge loads each flip-flop with its init bit. This has priority over the clock enable and the data.
- R10: F and G both programmed as 4-input odd parity (0x6996), H programmed as 3-input odd parity (0x96), both H selects at 0 and the X view on H make `x_out` the odd parity of `f_in`, `g_in` and `h_dir`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Cell clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_en | input | 1 | Configuration shift enable |
| cfg_bit | input | 1 | Serial configuration data |
| f_in | input | 4 | F table address |
| g_in | input | 4 | G table address |
| h_dir | input | 1 | H address bit 0, always direct |
| h_alt_a | input | 1 | Direct alternative for H address bit 1 |
| h_alt_b | input | 1 | Direct alternative for H address bit 2 |
| x_din | input | 1 | Direct data for the XQ flip-flop |
| y_din | input | 1 | Direct data for the YQ flip-flop |
| x_ce | input | 1 | XQ clock enable |
| y_ce | input | 1 | YQ clock enable |
| ff_sr | input | 1 | Synchronous load of the init values |
| x_out | output | 1 | Combinational X view |
| y_out | output | 1 | Combinational Y view |
| xq | output | 1 | Registered X output |
| yq | output | 1 | Registered Y output |

## Verification
The flip-flop clock enable can meet either the configuration shift or the init load in the same edge. The bench holds `x_ce`/`y_ce` high with the direct data at 1 during a whole configuration load. It expects the registered outputs to show the init bits that sat in the register just before the final shift, not the data. It then raises `ff_sr` with the enables still high and expects the newly loaded init values, not the selected source.

// File: rtl/lut_cell_pkg.sv
// Package: shared sizes and configuration layout for the logic cell.
// Assumes exactly two flip-flops and one 3-input merge table.
package lut_cell_pkg;
    localparam int unsigned BIG_K      = 4;
    localparam int unsigned SMALL_K    = 3;
    localparam int unsigned BIG_BITS   = 1 << BIG_K;
    localparam int unsigned SMALL_BITS = 1 << SMALL_K;
    localparam int unsigned DSEL_W     = 2;
    localparam int unsigned NUM_FF     = 2;
    localparam int unsigned OPT_BITS   = 4 + NUM_FF * (DSEL_W + 1);
    localparam int unsigned CFG_BITS   = 2 * BIG_BITS + SMALL_BITS + OPT_BITS;

    // Flip-flop data source codes.
    typedef enum logic [DSEL_W-1:0] {
        DSRC_F      = 2'b00,
        DSRC_G      = 2'b01,
        DSRC_H      = 2'b10,
        DSRC_DIRECT = 2'b11
    } dsrc_e;

    typedef struct packed {
        dsrc_e dsrc;
        logic  init;
    } ff_opt_t;

    // First member is the most significant; the first bit shifted in ends at the top.
    typedef struct packed {
        logic [BIG_BITS-1:0]   f_tab;
        logic [BIG_BITS-1:0]   g_tab;
        logic [SMALL_BITS-1:0] h_tab;
        logic                  ha_direct;
        logic                  hb_direct;
        logic                  x_use_h;
        logic                  y_use_h;
        ff_opt_t               ff_x;
        ff_opt_t               ff_y;
    } cell_cfg_t;
endpackage

// File: rtl/lut_cell_cfg.sv
// Module: serial configuration register of the cell.
// Shifts one bit per clock while enabled, MSB first; holds otherwise.
// Assumes the reset is synchronous and active low.
module lut_cell_cfg
    import lut_cell_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      cfg_en,
    input  logic      cfg_bit,
    output cell_cfg_t cfg
);
    logic [CFG_BITS-1:0] shift_q;

    // Purpose: clear on reset, shift in a configuration bit when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shift_q <= '0;
        end else if (cfg_en) begin
            shift_q <= {shift_q[CFG_BITS-2:0], cfg_bit};
        end
    end

    assign cfg = cell_cfg_t'(shift_q);
endmodule

// File: rtl/lut_cell_table.sv
// Module: K-input lookup table built as a binary mux tree.
// The delay is the same for every stored function. Assumes K >= 1.
module lut_cell_table #(
    parameter int unsigned K = 4
) (
    input  logic [(1<<K)-1:0] tab,
    input  logic [K-1:0]      addr,
    output logic              bit_out
);
    localparam int unsigned ENTRIES = 1 << K;

    // level[l] holds the candidates left after resolving address bits below l.
    logic [ENTRIES-1:0] level [K+1];

    assign level[0] = tab;

    for (genvar l = 0; l < K; l++) begin : g_stage
        localparam int unsigned NOUT = ENTRIES >> (l + 1);
        for (genvar n = 0; n < NOUT; n++) begin : g_node
            assign level[l+1][n] = addr[l] ? level[l][2*n+1] : level[l][2*n];
        end
        if (NOUT < ENTRIES) begin : g_pad
            assign level[l+1][ENTRIES-1:NOUT] = '0;
        end
    end

    assign bit_out = level[K][0];
endmodule

// File: rtl/lut_cell_ff.sv
// Module: one cell flip-flop with configured source, clock enable and init load.
// Priority: reset (to 0), then configuration hold or set/clear (to init), then enable.
module lut_cell_ff
    import lut_cell_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    cfg_hold,
    input  logic    sr,
    input  logic    ce,
    input  logic    f_res,
    input  logic    g_res,
    input  logic    h_res,
    input  logic    din,
    input  ff_opt_t opt,
    output logic    q
);
    logic d;

    // Purpose: pick the data source named by the configuration.
    always_comb begin
        unique case (opt.dsrc)
            DSRC_F:      d = f_res;
            DSRC_G:      d = g_res;
            DSRC_H:      d = h_res;
            DSRC_DIRECT: d = din;
            default:     d = 1'b0;
        endcase
    end

    // Purpose: state update with fixed priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= 1'b0;
        end else if (cfg_hold || sr) begin
            q <= opt.init;
        end else if (ce) begin
            q <= d;
        end
    end
endmodule

// File: rtl/lut_cell.sv
// Module: top of the configurable logic cell.
// F and G tables feed an H merge table, two views and two flip-flops.
// Assumes the configuration is loaded before the outputs are used.
module lut_cell
    import lut_cell_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_en,
    input  logic               cfg_bit,
    input  logic [BIG_K-1:0]   f_in,
    input  logic [BIG_K-1:0]   g_in,
    input  logic               h_dir,
    input  logic               h_alt_a,
    input  logic               h_alt_b,
    input  logic               x_din,
    input  logic               y_din,
    input  logic               x_ce,
    input  logic               y_ce,
    input  logic               ff_sr,
    output logic               x_out,
    output logic               y_out,
    output logic               xq,
    output logic               yq
);
    cell_cfg_t          cfg;
    logic               f_res;
    logic               g_res;
    logic               h_res;
    logic [SMALL_K-1:0] h_addr;
    logic [NUM_FF-1:0]  ce_v;
    logic [NUM_FF-1:0]  din_v;
    logic [NUM_FF-1:0]  q_v;
    ff_opt_t            opt_v [NUM_FF];

    lut_cell_cfg u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_en  (cfg_en),
        .cfg_bit (cfg_bit),
        .cfg     (cfg)
    );

    lut_cell_table #(.K(BIG_K)) u_f_tab (
        .tab     (cfg.f_tab),
        .addr    (f_in),
        .bit_out (f_res)
    );

    lut_cell_table #(.K(BIG_K)) u_g_tab (
        .tab     (cfg.g_tab),
        .addr    (g_in),
        .bit_out (g_res)
    );

    // Purpose: steer the two selectable H address bits; bit 0 is always direct.
    always_comb begin
        h_addr[0] = h_dir;
        h_addr[1] = cfg.ha_direct ? h_alt_a : f_res;
        h_addr[2] = cfg.hb_direct ? h_alt_b : g_res;
    end

    lut_cell_table #(.K(SMALL_K)) u_h_tab (
        .tab     (cfg.h_tab),
        .addr    (h_addr),
        .bit_out (h_res)
    );

    // Purpose: combinational views of the table results.
    always_comb begin
        x_out = cfg.x_use_h ? h_res : f_res;
        y_out = cfg.y_use_h ? h_res : g_res;
    end

    assign ce_v     = {y_ce, x_ce};
    assign din_v    = {y_din, x_din};
    assign opt_v[0] = cfg.ff_x;
    assign opt_v[1] = cfg.ff_y;

    for (genvar i = 0; i < NUM_FF; i++) begin : g_ff
        lut_cell_ff u_ff (
            .clk      (clk),
            .rst_n    (rst_n),
            .cfg_hold (cfg_en),
            .sr       (ff_sr),
            .ce       (ce_v[i]),
            .f_res    (f_res),
            .g_res    (g_res),
            .h_res    (h_res),
            .din      (din_v[i]),
            .opt      (opt_v[i]),
            .q        (q_v[i])
        );
    end

    assign xq = q_v[0];
    assign yq = q_v[1];
endmodule

// File: rtl/lut_cell_chk.sv
// Module: temporal checks for the logic cell, bound to the top.
// Assumes the reset is synchronous and active low.
module lut_cell_chk
    import lut_cell_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      cfg_en,
    input logic      cfg_bit,
    input logic      ff_sr,
    input logic      x_ce,
    input logic      y_ce,
    input logic      x_din,
    input logic      y_din,
    input logic      f_res,
    input logic      g_res,
    input logic      h_res,
    input logic      xq,
    input logic      yq,
    input cell_cfg_t cfg
);
    logic x_exp_d;
    logic y_exp_d;

    // Purpose: expected flip-flop data from the source codes of R5.
    always_comb begin
        case (cfg.ff_x.dsrc)
            DSRC_F:  x_exp_d = f_res;
            DSRC_G:  x_exp_d = g_res;
            DSRC_H:  x_exp_d = h_res;
            default: x_exp_d = x_din;
        endcase
        case (cfg.ff_y.dsrc)
            DSRC_F:  y_exp_d = f_res;
            DSRC_G:  y_exp_d = g_res;
            DSRC_H:  y_exp_d = h_res;
            default: y_exp_d = y_din;
        endcase
    end

    assert_shift_in_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_en |=> cfg.ff_y.init == $past(cfg_bit));

    assert_cfg_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |=> $stable(cfg));

    assert_x_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_en && !ff_sr && x_ce) |=> xq == $past(x_exp_d));

    assert_y_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_en && !ff_sr && y_ce) |=> yq == $past(y_exp_d));

    assert_x_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_en && !ff_sr && !x_ce) |=> $stable(xq));

    assert_y_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_en && !ff_sr && !y_ce) |=> $stable(yq));

    assert_cfg_init_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_en |=> (xq == $past(cfg.ff_x.init)) && (yq == $past(cfg.ff_y.init)));

    assert_sr_init_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ff_sr && !cfg_en) |=> (xq == $past(cfg.ff_x.init)) && (yq == $past(cfg.ff_y.init)));
endmodule

bind lut_cell lut_cell_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg_en  (cfg_en),
    .cfg_bit (cfg_bit),
    .ff_sr   (ff_sr),
    .x_ce    (x_ce),
    .y_ce    (y_ce),
    .x_din   (x_din),
    .y_din   (y_din),
    .f_res   (f_res),
    .g_res   (g_res),
    .h_res   (h_res),
    .xq      (xq),
    .yq      (yq),
    .cfg     (cfg)
);

// File: tb/lut_cell_tb.sv
`timescale 1ns/1ps
// Bench: directed scenarios for the logic cell, each task checks its own results.
module lut_cell_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_en = 1'b0, cfg_bit = 1'b0, ff_sr = 1'b0;
    logic [3:0] f_in = '0, g_in = '0;
    logic       h_dir = 1'b0, h_alt_a = 1'b0, h_alt_b = 1'b0;
    logic       x_din = 1'b0, y_din = 1'b0, x_ce = 1'b0, y_ce = 1'b0;
    logic       x_out, y_out, xq, yq;

    int tests_run = 0;
    int tests_failed = 0;

    // Bench copy of the intended configuration.
    logic [15:0] m_f = '0, m_g = '0;
    logic [7:0]  m_h = '0;
    logic        m_ha = 0, m_hb = 0, m_xh = 0, m_yh = 0, m_xi = 0, m_yi = 0;
    logic [1:0]  m_xs = '0, m_ys = '0;
    logic [49:0] last_vec = '0;

    always #2.5 clk = ~clk;

    lut_cell u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_bit(cfg_bit),
        .f_in(f_in), .g_in(g_in), .h_dir(h_dir), .h_alt_a(h_alt_a), .h_alt_b(h_alt_b),
        .x_din(x_din), .y_din(y_din), .x_ce(x_ce), .y_ce(y_ce), .ff_sr(ff_sr),
        .x_out(x_out), .y_out(y_out), .xq(xq), .yq(yq)
    );

    task automatic check(input string req, input string what, input logic act, input logic exp);
        tests_run++;
        if (act !== exp) begin
            tests_failed++;
            $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
        end
    endtask

    function automatic logic mdl_f();
        return m_f[f_in];
    endfunction
    function automatic logic mdl_g();
        return m_g[g_in];
    endfunction
    function automatic logic mdl_h();
        logic a, b;
        a = m_ha ? h_alt_a : m_f[f_in];
        b = m_hb ? h_alt_b : m_g[g_in];
        return m_h[{b, a, h_dir}];
    endfunction
    function automatic logic mdl_src(input logic [1:0] s, input logic d);
        case (s)
            2'b00:   return mdl_f();
            2'b01:   return mdl_g();
            2'b10:   return mdl_h();
            default: return d;
        endcase
    endfunction

    task automatic set_ins(input logic [10:0] v);
        f_in = v[3:0]; g_in = v[7:4]; h_dir = v[8]; h_alt_a = v[9]; h_alt_b = v[10];
    endtask

    // Shift the model configuration in, first bit = F table bit 15 (R4).
    task automatic load_cfg();
        logic [49:0] vec;
        vec = {m_f, m_g, m_h, m_ha, m_hb, m_xh, m_yh, m_xs, m_xi, m_ys, m_yi};
        last_vec = vec;
        for (int i = 49; i >= 0; i--) begin
            @(negedge clk);
            cfg_en = 1'b1;
            cfg_bit = vec[i];
        end
        @(negedge clk);
        cfg_en = 1'b0;
    endtask

    task automatic t_reset();
        check("R7", "x_out after reset", x_out, 1'b0);
        check("R7", "y_out after reset", y_out, 1'b0);
        check("R7", "xq after reset", xq, 1'b0);
        check("R7", "yq after reset", yq, 1'b0);
    endtask

    task automatic t_tables();
        m_f = 16'hA5C3; m_g = 16'h1E69; m_h = 8'hE8;
        m_ha = 0; m_hb = 0; m_xh = 0; m_yh = 0;
        m_xs = 2'b00; m_ys = 2'b01; m_xi = 0; m_yi = 0;
        load_cfg();
        for (int v = 0; v < 256; v++) begin
            set_ins(11'(v));
            #0.5;
            check("R1", "x_out shows F", x_out, mdl_f());
            check("R1", "y_out shows G", y_out, mdl_g());
        end
    endtask

    task automatic t_merge(input logic ha, input logic hb);
        m_f = 16'h3C5A; m_g = 16'hF00D; m_h = 8'h4B;
        m_ha = ha; m_hb = hb; m_xh = 1; m_yh = 1;
        load_cfg();
        for (int v = 0; v < 2048; v += 3) begin
            set_ins(11'(v));
            #0.5;
            check("R2", "H through x_out", x_out, mdl_h());
            check("R3", "H through y_out", y_out, mdl_h());
        end
    endtask

    task automatic t_parity();
        m_f = 16'h6996; m_g = 16'h6996; m_h = 8'h96;
        m_ha = 0; m_hb = 0; m_xh = 1; m_yh = 0;
        load_cfg();
        for (int v = 0; v < 512; v++) begin
            set_ins(11'(v));
            #0.5;
            check("R10", "9-input parity", x_out, ^v[8:0]);
        end
    endtask

    // With cfg_en low the register ignores cfg_bit: outputs keep the parity function.
    task automatic t_cfg_hold();
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            cfg_bit = i[0];
        end
        for (int v = 0; v < 512; v += 37) begin
            set_ins(11'(v));
            #0.5;
            check("R4", "config kept with cfg_en low", x_out, ^v[8:0]);
        end
    endtask

    task automatic t_regs();
        m_f = 16'hA5C3; m_g = 16'h1E69; m_h = 8'hE8;
        m_ha = 0; m_hb = 1; m_xh = 0; m_yh = 1; m_xi = 0; m_yi = 0;
        for (int s = 0; s < 4; s++) begin
            m_xs = 2'(s); m_ys = 2'(3 - s);
            load_cfg();
            for (int p = 0; p < 6; p++) begin
                logic ex, ey;
                @(negedge clk);
                set_ins(11'(p * 347 + s * 91));
                x_din = p[0]; y_din = ~p[0];
                x_ce = 1'b1; y_ce = 1'b1;
                #0.5;
                ex = mdl_src(m_xs, x_din);
                ey = mdl_src(m_ys, y_din);
                @(posedge clk); #0.5;
                check("R5", "xq loads source", xq, ex);
                check("R5", "yq loads source", yq, ey);
                @(negedge clk);
                x_ce = 1'b0; y_ce = 1'b0;
                set_ins(~11'(p * 347 + s * 91));
                x_din = ~x_din; y_din = ~y_din;
                @(posedge clk); #0.5;
                check("R6", "xq holds with enable low", xq, ex);
                check("R6", "yq holds with enable low", yq, ey);
            end
        end
    endtask

    // Clock enable and configuration load in the same edges, then set/clear with enable.
    task automatic t_collide();
        m_f = 16'h0000; m_g = 16'h0000; m_h = 8'h00;
        m_ha = 0; m_hb = 0; m_xh = 0; m_yh = 0;
        m_xs = 2'b11; m_ys = 2'b11; m_xi = 0; m_yi = 0;
        load_cfg();
        @(negedge clk);
        x_din = 1'b1; y_din = 1'b1; x_ce = 1'b1; y_ce = 1'b1;
        @(posedge clk); #0.5;
        check("R6", "xq set by direct data", xq, 1'b1);
        check("R6", "yq set by direct data", yq, 1'b1);
        // Keep enables and data high through the whole load.
        m_xs = 2'b10; m_xi = 1; m_ys = 2'b10; m_yi = 0;
        load_cfg();
        #0.5;
        check("R8", "xq held at pre-edge init during load", xq, last_vec[4]);
        check("R8", "yq held at pre-edge init during load", yq, last_vec[1]);
        @(negedge clk);
        x_din = 1'b1; y_din = 1'b1;
        ff_sr = 1'b1;
        @(posedge clk); #0.5;
        check("R9", "ff_sr beats enable on xq", xq, 1'b1);
        check("R9", "ff_sr beats enable on yq", yq, 1'b0);
        @(negedge clk);
        ff_sr = 1'b0; x_ce = 1'b0; y_ce = 1'b0;
    endtask

    task automatic t_rst_clear();
        m_f = 16'hFFFF; m_g = 16'hFFFF; m_h = 8'hFF;
        m_ha = 0; m_hb = 0; m_xh = 0; m_yh = 0;
        m_xs = 2'b00; m_ys = 2'b01; m_xi = 1; m_yi = 1;
        load_cfg();
        @(negedge clk);
        ff_sr = 1'b1;
        @(negedge clk);
        ff_sr = 1'b0;
        #0.5;
        check("R9", "xq init 1 before reset", xq, 1'b1);
        check("R1", "x_out all-ones table", x_out, 1'b1);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #0.5;
        check("R7", "x_out cleared by reset", x_out, 1'b0);
        check("R7", "y_out cleared by reset", y_out, 1'b0);
        check("R7", "xq cleared by reset", xq, 1'b0);
        check("R7", "yq cleared by reset", yq, 1'b0);
    endtask

    initial begin
        #(200000 * 5);
        tests_failed++;
        $display("FAIL watchdog expired: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end

    initial begin
        set_ins('0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_tables();
        t_merge(1'b0, 1'b0);
        t_merge(1'b1, 1'b1);
        t_merge(1'b1, 1'b0);
        t_parity();
        t_cfg_hold();
        t_regs();
        t_collide();
        t_rst_clear();
        $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end
endmodule